// File: doc/BRIEF.md
# Self-Synchronizing Multi-Polynomial PRBS Checker

This block checks a received parallel word stream against one of four pseudo-random binary sequences chosen at run time. When no lock is held, it keeps a local history register filled straight from the incoming bits. This lets it adopt whatever phase the transmitter is sending, with no seed exchange. After a run of error-free bits it declares lock. From then on its history register runs freely on its own predictions. Every received bit that disagrees with the prediction is counted once.

It sits behind word alignment and deserialization. Three qualifiers gate it: a clock-enable flag, a test-enable flag, and a set of per-polynomial enable bits. Firmware or a test harness reads the lock flag and the saturating error counter. An error-clear input zeroes the counter without disturbing lock. If too many errors arrive within a short span, lock is dropped and the checker reseeds itself from the live data.

Top module: `prbs_sync_checker`

## Requirements
- R1: The checker is active only when `prbs_clk_en` and `test_en` are both 1 and exactly one bit of `poly_en` is set. The encoding is bit 0 = PRBS-7, bit 1 = PRBS-9, bit 2 = PRBS-23, bit 3 = PRBS-31. Zero or several set bits leave it inactive.
- R2: Bit 0 of `rx_data` is the earliest bit in time. The sequence obeys b[n] = b[n-N] xor b[n-M], with (N,M) = (7,6), (9,5), (23,18) and (31,28). A stream of a different polynomial does not produce lock.
- R3: While unlocked, each received bit is shifted into the history and compared with the bit predicted from that history. Lock is set by the bit that completes 64 consecutive matching bits.
- R4: While locked, the history advances on predicted bits. Each received bit that differs from its prediction adds one to `err_count`.
- R5: `err_count` saturates at its all-ones value and stays there while further errors arrive.
- R6: With `err_clr` high in an active cycle, `err_count` becomes 0 after that edge, even when the same word holds errors. The lock state is updated normally.
- R7: While inactive, `locked` and `err_count` read 0 one cycle later, and all internal tracking state is cleared.
- R8: Locked operation is split into 64-bit windows, counted from the bit after lock. The 8th error within one window clears lock, and reseeding from received bits restarts at the next bit. Seven errors in a window keep lock.
- R9: An active cycle with `rx_valid` low changes nothing except for the effect of `err_clr`.
- R10: The outputs are registered. They reflect a word in the cycle after the edge that accepts it, and both read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prbs_clk_en | input | 1 | Checker clock enable qualifier |
| test_en | input | 1 | Verifier enable |
| poly_en | input | 4 | One-hot polynomial enables |
| rx_data | input | DATA_W | Received word, bit 0 earliest |
| rx_valid | input | 1 | Word qualifier |
| err_clr | input | 1 | Synchronous error-counter clear |
| locked | output | 1 | Lock status |
| err_count | output | ERR_W | Saturating bit-error count |

## Verification
Suppose the history or the run counters held a wrong value. Lock would then appear early, late or not at all. For a clean PRBS-31 stream, lock should appear within about eight 16-bit words. A free-running prediction that drifts after lock shows up as a rising `err_count` on the very next word, and at most one word later as a dropped lock. A wrong window position can only be seen in bursts close to eight errors. For that reason the bench compares lock and count with a bit-serial model at every clock, and it drives error patterns both below and above the loss threshold.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int HIST_W = 31;

    typedef logic [HIST_W-1:0] hist_t;

    // Feedback taps: bit k of the mask selects the bit received k+1 bits ago.
    function automatic hist_t tap_mask(input logic [3:0] sel);
        hist_t m;
        m = '0;
        unique case (sel)
            4'b0001: begin m[6]  = 1'b1; m[5]  = 1'b1; end
            4'b0010: begin m[8]  = 1'b1; m[4]  = 1'b1; end
            4'b0100: begin m[22] = 1'b1; m[17] = 1'b1; end
            4'b1000: begin m[30] = 1'b1; m[27] = 1'b1; end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/prbs_mode_decode.sv
module prbs_mode_decode
    import prbs_chk_pkg::*;
(
    input  logic       clk_en_i,
    input  logic       test_en_i,
    input  logic [3:0] poly_en_i,
    output logic       active_o,
    output hist_t      mask_o
);

    always_comb begin
        active_o = clk_en_i && test_en_i && $onehot(poly_en_i);
        mask_o   = tap_mask(poly_en_i);
    end

endmodule

// File: rtl/prbs_word_engine.sv
module prbs_word_engine
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int LOCK_RUN  = 64,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 8,
    localparam int GOOD_W   = $clog2(LOCK_RUN + 1),
    localparam int POS_W    = $clog2(WIN_LEN + 1),
    localparam int WE_W     = $clog2(LOSS_ERRS + 1),
    localparam int NERR_W   = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] data_i,
    input  hist_t             mask_i,
    input  hist_t             hist_i,
    input  logic              locked_i,
    input  logic [GOOD_W-1:0] good_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [WE_W-1:0]   werr_i,
    output hist_t             hist_o,
    output logic              locked_o,
    output logic [GOOD_W-1:0] good_o,
    output logic [POS_W-1:0]  pos_o,
    output logic [WE_W-1:0]   werr_o,
    output logic [NERR_W-1:0] nerr_o
);

    // Bit-serial walk over the word, earliest bit first.
    always_comb begin
        hist_t             h;
        logic              lk;
        logic [GOOD_W-1:0] g;
        logic [POS_W-1:0]  wp;
        logic [WE_W-1:0]   we;
        logic [NERR_W-1:0] n;
        logic              pred;
        logic              miss;
        h  = hist_i;
        lk = locked_i;
        g  = good_i;
        wp = pos_i;
        we = werr_i;
        n  = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pred = ^(h & mask_i);
            miss = data_i[i] ^ pred;
            if (!lk) begin
                // Seeding: the history follows the line.
                h = {h[HIST_W-2:0], data_i[i]};
                if (miss) begin
                    g = '0;
                end else if (g < GOOD_W'(LOCK_RUN)) begin
                    g = g + 1'b1;
                end
                if (g == GOOD_W'(LOCK_RUN)) begin
                    lk = 1'b1;
                    g  = '0;
                    wp = '0;
                    we = '0;
                end
            end else begin
                // Tracking: the history free-runs on its own prediction.
                h  = {h[HIST_W-2:0], pred};
                wp = wp + 1'b1;
                if (miss) begin
                    n  = n + 1'b1;
                    we = we + 1'b1;
                end
                if (we >= WE_W'(LOSS_ERRS)) begin
                    lk = 1'b0;
                    g  = '0;
                    wp = '0;
                    we = '0;
                end else if (wp == POS_W'(WIN_LEN)) begin
                    wp = '0;
                    we = '0;
                end
            end
        end
        hist_o   = h;
        locked_o = lk;
        good_o   = g;
        pos_o    = wp;
        werr_o   = we;
        nerr_o   = n;
    end

endmodule

// File: rtl/prbs_err_accum.sv
module prbs_err_accum #(
    parameter int ERR_W  = 16,
    parameter int NERR_W = 5,
    localparam int SUM_W = ERR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              clr_i,
    input  logic              add_en_i,
    input  logic [NERR_W-1:0] add_i,
    output logic [ERR_W-1:0]  count_o
);

    typedef struct packed {
        logic [ERR_W-1:0] cnt;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = SUM_W'(acc_q.cnt) + SUM_W'(add_i);
        acc_d = acc_q;
        if (!active_i || clr_i) begin
            acc_d.cnt = '0;
        end else if (add_en_i) begin
            acc_d.cnt = sum[ERR_W] ? '1 : sum[ERR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign count_o = acc_q.cnt;

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && clr_i) |=> (count_o == '0));

    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !clr_i && (count_o == '1)) |=> (count_o == '1));

    p_no_decrease_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !clr_i) |=> (count_o >= $past(count_o)));

endmodule

// File: rtl/prbs_sync_checker.sv
module prbs_sync_checker
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ERR_W     = 16,
    parameter int LOCK_RUN  = 64,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prbs_clk_en,
    input  logic              test_en,
    input  logic [3:0]        poly_en,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              err_clr,
    output logic              locked,
    output logic [ERR_W-1:0]  err_count
);

    localparam int GOOD_W = $clog2(LOCK_RUN + 1);
    localparam int POS_W  = $clog2(WIN_LEN + 1);
    localparam int WE_W   = $clog2(LOSS_ERRS + 1);
    localparam int NERR_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic              locked;
        logic [GOOD_W-1:0] good;
        logic [POS_W-1:0]  pos;
        logic [WE_W-1:0]   werr;
        hist_t             hist;
    } sync_t;

    sync_t st_d, st_q;
    logic  active;
    hist_t mask;

    hist_t             eng_hist;
    logic              eng_locked;
    logic [GOOD_W-1:0] eng_good;
    logic [POS_W-1:0]  eng_pos;
    logic [WE_W-1:0]   eng_werr;
    logic [NERR_W-1:0] eng_nerr;

    prbs_mode_decode u_decode (
        .clk_en_i  (prbs_clk_en),
        .test_en_i (test_en),
        .poly_en_i (poly_en),
        .active_o  (active),
        .mask_o    (mask)
    );

    prbs_word_engine #(
        .DATA_W    (DATA_W),
        .LOCK_RUN  (LOCK_RUN),
        .WIN_LEN   (WIN_LEN),
        .LOSS_ERRS (LOSS_ERRS)
    ) u_engine (
        .data_i   (rx_data),
        .mask_i   (mask),
        .hist_i   (st_q.hist),
        .locked_i (st_q.locked),
        .good_i   (st_q.good),
        .pos_i    (st_q.pos),
        .werr_i   (st_q.werr),
        .hist_o   (eng_hist),
        .locked_o (eng_locked),
        .good_o   (eng_good),
        .pos_o    (eng_pos),
        .werr_o   (eng_werr),
        .nerr_o   (eng_nerr)
    );

    prbs_err_accum #(
        .ERR_W  (ERR_W),
        .NERR_W (NERR_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .clr_i    (err_clr),
        .add_en_i (rx_valid),
        .add_i    (eng_nerr),
        .count_o  (err_count)
    );

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d = '0;
        end else if (rx_valid) begin
            st_d.locked = eng_locked;
            st_d.good   = eng_good;
            st_d.pos    = eng_pos;
            st_d.werr   = eng_werr;
            st_d.hist   = eng_hist;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!locked && (err_count == '0)));

    p_gap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !rx_valid && !err_clr) |=> ($stable(locked) && $stable(err_count)));

    p_lock_needs_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !(active && rx_valid)) |=> !locked);

    p_count_only_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && $countones(poly_en) > 1) |=> (err_count == '0));

endmodule

// File: tb/prbs_sync_checker_tb_top.sv
`timescale 1ns/1ps
module prbs_sync_checker_tb_top;

    localparam int W  = 16;
    localparam int EW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b0, te = 1'b0, vld = 1'b0, clr = 1'b0;
    logic [3:0]    pe = 4'b0000;
    logic [W-1:0]  dat = '0;
    logic          lk;
    logic [EW-1:0] ec;

    // shadow controls, applied on the next cycle together with the model step
    logic       n_rst = 1'b0, n_ce = 1'b0, n_te = 1'b0;
    logic [3:0] n_pe = 4'b0000;

    always #10 clk = ~clk;

    prbs_sync_checker #(.DATA_W(W), .ERR_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .prbs_clk_en(ce), .test_en(te), .poly_en(pe),
        .rx_data(dat), .rx_valid(vld), .err_clr(clr), .locked(lk), .err_count(ec)
    );

    int    checks = 0, errors = 0;
    bit    done = 0;
    string cur_req = "R10";

    // behavioural reference
    bit mh[$];
    int m_lock, m_good, m_pos, m_werr, m_cnt;
    // stimulus generator
    bit gq[$];
    int gn = 7, gm = 6;

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic model_clear();
        mh.delete();
        repeat (31) mh.push_back(1'b0);
        m_lock = 0; m_good = 0; m_pos = 0; m_werr = 0; m_cnt = 0;
    endtask

    function automatic void taps_of(input logic [3:0] s, output int n, output int m);
        case (s)
            4'b0001: begin n = 7;  m = 6;  end
            4'b0010: begin n = 9;  m = 5;  end
            4'b0100: begin n = 23; m = 18; end
            default: begin n = 31; m = 28; end
        endcase
    endfunction

    task automatic model_step();
        int n, m, add;
        bit act, p, e;
        act = ce && te && ($countones(pe) == 1);
        if (!rst_n || !act) begin
            model_clear();
            return;
        end
        taps_of(pe, n, m);
        add = 0;
        if (vld) begin
            for (int i = 0; i < W; i++) begin
                p = mh[$-(n-1)] ^ mh[$-(m-1)];
                e = dat[i] ^ p;
                if (m_lock == 0) begin
                    mh.push_back(dat[i]);
                    void'(mh.pop_front());
                    m_good = e ? 0 : m_good + 1;
                    if (m_good >= 64) begin
                        m_lock = 1; m_good = 0; m_pos = 0; m_werr = 0;
                    end
                end else begin
                    mh.push_back(p);
                    void'(mh.pop_front());
                    m_pos++;
                    if (e) begin add++; m_werr++; end
                    if (m_werr >= 8) begin
                        m_lock = 0; m_good = 0; m_pos = 0; m_werr = 0;
                    end else if (m_pos == 64) begin
                        m_pos = 0; m_werr = 0;
                    end
                end
            end
        end
        if (clr) m_cnt = 0;
        else begin
            m_cnt = m_cnt + add;
            if (m_cnt > 255) m_cnt = 255;
        end
    endtask

    task automatic gen_reset(input int n, input int m);
        gq.delete();
        repeat (31) gq.push_back(1'b1);
        gn = n; gm = m;
    endtask

    function automatic bit gen_bit();
        bit b;
        b = gq[$-(gn-1)] ^ gq[$-(gm-1)];
        gq.push_back(b);
        void'(gq.pop_front());
        return b;
    endfunction

    task automatic cycle(input logic [W-1:0] word, input bit valid, input bit c);
        @(negedge clk);
        chk(cur_req, "locked", int'(lk), m_lock);
        chk(cur_req, "err_count", int'(ec), m_cnt);
        rst_n = n_rst; ce = n_ce; te = n_te; pe = n_pe;
        dat = word; vld = valid; clr = c;
        model_step();
    endtask

    task automatic send(input int nw, input logic [W-1:0] flip, input bit c);
        logic [W-1:0] w;
        for (int k = 0; k < nw; k++) begin
            for (int i = 0; i < W; i++) w[i] = gen_bit();
            cycle(w ^ flip, 1'b1, c);
        end
    endtask

    task automatic settle();
        cycle('0, 1'b0, 1'b0);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        model_clear();
        repeat (3) cycle('0, 1'b0, 1'b0);
        chk("R10", "reset locked", int'(lk), 0);
        chk("R10", "reset err_count", int'(ec), 0);
        n_rst = 1'b1; n_ce = 1'b1; n_te = 1'b1;
        settle();

        // R2/R3: each polynomial locks on its own clean stream
        for (int k = 0; k < 4; k++) begin
            int n, m;
            n_pe = 4'(1 << k);
            taps_of(n_pe, n, m);
            gen_reset(n, m);
            cur_req = "R3";
            send(12, '0, 1'b0);
            settle();
            chk("R2", "lock on matching polynomial", int'(lk), 1);
            cur_req = "R7";
            n_ce = 1'b0;
            settle(); settle();
            chk("R7", "locked while clock enable low", int'(lk), 0);
            chk("R7", "err_count while clock enable low", int'(ec), 0);
            n_ce = 1'b1;
        end

        // R2: PRBS-7 data against PRBS-9 selection must not lock
        cur_req = "R2";
        n_pe = 4'b0010;
        gen_reset(7, 6);
        send(12, '0, 1'b0);
        settle();
        chk("R2", "no lock on foreign polynomial", int'(lk), 0);
        n_ce = 1'b0; settle(); n_ce = 1'b1;

        // R4: isolated single-bit errors are counted
        cur_req = "R4";
        gen_reset(9, 5);
        send(12, '0, 1'b0);
        send(1, 16'h0010, 1'b0);
        send(2, '0, 1'b0);
        send(1, 16'h0100, 1'b0);
        send(1, '0, 1'b0);
        send(1, 16'h8000, 1'b0);
        send(3, '0, 1'b0);
        settle();
        chk("R4", "three single errors", int'(ec), 3);
        chk("R4", "lock kept", int'(lk), 1);

        // R9: invalid words with garbage change nothing
        cur_req = "R9";
        repeat (5) cycle(16'hDEAD, 1'b0, 1'b0);
        settle();
        chk("R9", "count held over gaps", int'(ec), 3);
        chk("R9", "lock held over gaps", int'(lk), 1);
        send(4, '0, 1'b0);
        settle();
        chk("R9", "stream continues after gaps", int'(ec), 3);

        // R6: clear wins over same-cycle errors, lock untouched
        cur_req = "R6";
        send(1, 16'h0001, 1'b1);
        settle();
        chk("R6", "count after clear", int'(ec), 0);
        chk("R6", "lock after clear", int'(lk), 1);

        // R8: seven errors keep lock, a full-word burst drops it, relock follows
        cur_req = "R8";
        send(5, '0, 1'b0);
        send(1, 16'h007F, 1'b0);
        settle();
        chk("R8", "seven errors keep lock", int'(lk), 1);
        chk("R8", "seven errors counted", int'(ec), 7);
        send(5, '0, 1'b0);
        send(1, 16'hFFFF, 1'b0);
        settle();
        chk("R8", "burst drops lock", int'(lk), 0);
        send(12, '0, 1'b0);
        settle();
        chk("R8", "relock after reseed", int'(lk), 1);

        // R1: multi-hot polynomial and test enable low are inactive
        cur_req = "R1";
        n_pe = 4'b0011;
        settle(); settle();
        chk("R1", "multi-hot lock", int'(lk), 0);
        chk("R1", "multi-hot count", int'(ec), 0);
        n_pe = 4'b0010;
        gen_reset(9, 5);
        send(12, '0, 1'b0);
        n_te = 1'b0;
        settle(); settle();
        chk("R1", "test enable low lock", int'(lk), 0);
        n_te = 1'b1;

        // R5: saturation
        cur_req = "R5";
        gen_reset(9, 5);
        send(12, '0, 1'b0);
        send(300, 16'h0400, 1'b0);
        settle();
        chk("R5", "saturated count", int'(ec), 255);
        chk("R5", "lock during saturation", int'(lk), 1);
        send(1, 16'h0400, 1'b1);
        settle();
        chk("R6", "clear from saturation", int'(ec), 0);
        settle();

        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (R10): run did not complete");
            report();
            $finish;
        end
    end

endmodule